// File: doc/BRIEF.md
# Set-Grouped Event Counter Bank

This block is a bank of 64-bit performance counters for a shared cache. Every clock cycle the cache presents four groups of one-bit event strobes. Each counter has a configuration register that picks exactly one group and holds a mask of events within that group. In each cycle the counter adds the number of masked strobes that are high, so several simultaneous events are all counted.

Software reaches the configuration registers, the count registers and a 64-bit client-filter register through a 32-bit register port. Each 64-bit register is split into two words: the low word at the register's offset and the high word at offset + 4. Software stops a counter by writing zero to its configuration. Before starting a counter, it usually presets the count to zero. There is no overflow signal. A count wraps silently at 2^64.

Top module: `evbank_top`

## Requirements
- R1: Reset (synchronous, active low) clears every configuration, count and client-filter register, so all of them read as zero afterwards.
- R2: Configuration register i is at offset 0x2000 + 8*i and count register i at 0x3000 + 8*i. The client-filter register is at 0x2800. Each 64-bit register has its low word at its offset and its high word at offset + 4. A word write changes only its own half.
- R3: Configuration bits [7:0] select the group. Bit 8+k enables event k of that group. Groups 1, 2, 3 and 4 have 20, 19, 14 and 1 events, and their strobes arrive on the inputs ev_grp1 through ev_grp4 (event k on bit k).
- R4: In every cycle a counter adds the population count of (strobes of its group AND its mask). Other groups never contribute.
- R5: A counter whose group field is 0 or above 4 (this includes an all-zero configuration) holds its value.
- R6: Mask bits at or above the selected group's event count add nothing.
- R7: A bus write to either word of a count register takes priority over that cycle's increment, which is lost. The other word keeps its value.
- R8: A count wraps modulo 2^64.
- R9: Reads of unmapped offsets, including counter indices at or above NCNT, return zero. Writes to those offsets change nothing.
- R10: The client-filter register stores both words as written and can be cleared by writing zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one 32-bit word |
| bus_addr | input | 14 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_grp1 | input | 20 | Event strobes, group 1 |
| ev_grp2 | input | 19 | Event strobes, group 2 |
| ev_grp3 | input | 14 | Event strobes, group 3 |
| ev_grp4 | input | 1 | Event strobe, group 4 |

## Verification
The bench fires several strobes of one group in the same cycle. A design that adds only one per cycle under-counts, and a design that lets another group leak in over-counts. It writes a count register in the same cycle as an event, so a design that adds the increment on top of the written value reads one too high. It also writes a single word and checks that the other half is unchanged. Further tests cover configurations with invalid groups or with every mask bit set, a preset just below 2^64 that must wrap to a small value, and an address one counter past the last one. A design that decodes that address would store and return the data instead of zero.

// File: rtl/evbank_pkg.sv
// Shared sizes and helpers for the grouped event counter bank.
package evbank_pkg;
    localparam int NGROUPS = 4;
    localparam int CNT_W   = 64;
    localparam int GRP_W   = 8;
    localparam int MASK_W  = CNT_W - GRP_W;
    localparam int G1_N    = 20;
    localparam int G2_N    = 19;
    localparam int G3_N    = 14;
    localparam int G4_N    = 1;
    localparam int INC_W   = $clog2(MASK_W + 1);

    // Number of set bits in a masked strobe vector.
    function automatic logic [INC_W-1:0] popcnt(input logic [MASK_W-1:0] v);
        logic [INC_W-1:0] s;
        s = '0;
        for (int b = 0; b < MASK_W; b++) s = s + INC_W'(v[b]);
        return s;
    endfunction
endpackage

// File: rtl/evbank_decode.sv
// Address decoder for the counter bank.
// Assumes word-aligned 32-bit accesses. A misaligned address or a counter
// index at or above NCNT decodes as unmapped.
module evbank_decode #(
    parameter int NCNT   = 4,
    parameter int ADDR_W = 14,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_hit,
    output logic              cnt_hit,
    output logic              flt_hit,
    output logic [IDX_W-1:0]  idx,
    output logic              hi_word
);
    localparam logic [4:0] SEL_PAGE = 5'h10;  // 0x2000 >> 9
    localparam logic [4:0] CNT_PAGE = 5'h18;  // 0x3000 >> 9

    logic aligned, idx_ok;

    // Split the offset into region, counter index and word half.
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        idx     = addr[8:3];
        hi_word = addr[2];
        idx_ok  = ({1'b0, idx} < (IDX_W + 1)'(NCNT));
        sel_hit = aligned && idx_ok && (addr[13:9] == SEL_PAGE);
        cnt_hit = aligned && idx_ok && (addr[13:9] == CNT_PAGE);
        flt_hit = aligned && (addr[13:3] == 11'h500);  // 0x2800 >> 3
    end
endmodule

// File: rtl/evbank_counter.sv
// One counter slot: a configuration register (group in bits [7:0], event
// mask above it) and a 64-bit count. Each cycle the count adds the number
// of masked strobes of the selected group. A bus write to the count wins
// over that cycle's increment. The strobe vectors arrive zero-padded, so
// mask bits beyond a group's size select nothing.
module evbank_counter
    import evbank_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel_we_lo,
    input  logic                           sel_we_hi,
    input  logic                           cnt_we_lo,
    input  logic                           cnt_we_hi,
    input  logic [31:0]                    wdata,
    input  logic [NGROUPS-1:0][MASK_W-1:0] ev_vec,
    output logic [CNT_W-1:0]               sel_q,
    output logic [CNT_W-1:0]               cnt_q
);
    logic [GRP_W-1:0]  grp;
    logic [MASK_W-1:0] hits;
    logic [INC_W-1:0]  inc;
    logic              grp_valid;

    // Mask the strobes of the selected group and count them.
    always_comb begin
        grp       = sel_q[GRP_W-1:0];
        hits      = '0;
        grp_valid = (grp >= 8'd1) && (grp <= 8'(NGROUPS));
        if (grp_valid) hits = ev_vec[grp - 8'd1] & sel_q[CNT_W-1:GRP_W];
        inc = popcnt(hits);
    end

    // Configuration register, written one word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else begin
            if (sel_we_lo) sel_q[31:0]  <= wdata;
            if (sel_we_hi) sel_q[63:32] <= wdata;
        end
    end

    // Count register: a bus write replaces the increment for that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_we_lo || cnt_we_hi) begin
            if (cnt_we_lo) cnt_q[31:0]  <= wdata;
            if (cnt_we_hi) cnt_q[63:32] <= wdata;
        end else cnt_q <= cnt_q + CNT_W'(inc);
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (cnt_q == '0 && sel_q == '0));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_valid && !cnt_we_lo && !cnt_we_hi) |=> $stable(cnt_q));
    // R7
    wr_lo_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we_lo && !cnt_we_hi) |=> (cnt_q[31:0] == $past(wdata) && cnt_q[63:32] == $past(cnt_q[63:32])));
    // R7
    wr_hi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we_hi && !cnt_we_lo) |=> (cnt_q[63:32] == $past(wdata) && cnt_q[31:0] == $past(cnt_q[31:0])));
    // R6
    inc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(inc) <= G1_N);
endmodule

// File: rtl/evbank_top.sv
// Grouped event counter bank: NCNT counter slots plus a client-filter
// register behind a 32-bit word port. Reads are combinational from
// bus_addr. Unmapped offsets read as zero and ignore writes.
module evbank_top
    import evbank_pkg::*;
#(
    parameter int NCNT   = 4,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [G1_N-1:0]   ev_grp1,
    input  logic [G2_N-1:0]   ev_grp2,
    input  logic [G3_N-1:0]   ev_grp3,
    input  logic [G4_N-1:0]   ev_grp4
);
    localparam int IDX_W = 6;

    logic                           sel_hit, cnt_hit, flt_hit, hi_word;
    logic [IDX_W-1:0]               idx;
    logic [NGROUPS-1:0][MASK_W-1:0] ev_vec;
    logic [CNT_W-1:0]               sel_q [NCNT];
    logic [CNT_W-1:0]               cnt_q [NCNT];
    logic [CNT_W-1:0]               flt_q;
    logic [CNT_W-1:0]               rd64;

    evbank_decode #(.NCNT(NCNT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr(bus_addr), .sel_hit(sel_hit), .cnt_hit(cnt_hit),
        .flt_hit(flt_hit), .idx(idx), .hi_word(hi_word)
    );

    // Zero-pad each strobe group to the mask width.
    always_comb begin
        ev_vec[0] = MASK_W'(ev_grp1);
        ev_vec[1] = MASK_W'(ev_grp2);
        ev_vec[2] = MASK_W'(ev_grp3);
        ev_vec[3] = MASK_W'(ev_grp4);
    end

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        logic me;
        assign me = bus_wr && (idx == IDX_W'(i));
        evbank_counter u_cnt (
            .clk(clk), .rst_n(rst_n),
            .sel_we_lo(me && sel_hit && !hi_word), .sel_we_hi(me && sel_hit && hi_word),
            .cnt_we_lo(me && cnt_hit && !hi_word), .cnt_we_hi(me && cnt_hit && hi_word),
            .wdata(bus_wdata), .ev_vec(ev_vec),
            .sel_q(sel_q[i]), .cnt_q(cnt_q[i])
        );
    end

    // Client-filter register, stored one word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else if (bus_wr && flt_hit) begin
            if (hi_word) flt_q[63:32] <= bus_wdata;
            else         flt_q[31:0]  <= bus_wdata;
        end
    end

    // Read mux: pick the register, then the word half.
    always_comb begin
        rd64 = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (idx == IDX_W'(i) && sel_hit) rd64 = sel_q[i];
            if (idx == IDX_W'(i) && cnt_hit) rd64 = cnt_q[i];
        end
        if (flt_hit) rd64 = flt_q;
        bus_rdata = hi_word ? rd64[63:32] : rd64[31:0];
    end

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_hit || cnt_hit || flt_hit) |-> bus_rdata == 32'h0);
    // R10
    flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && flt_hit) |=> $stable(flt_q));
endmodule

// File: tb/tb_evbank_top.sv
`timescale 1ns/1ps
module tb_evbank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [19:0] ev_grp1 = '0;
    logic [18:0] ev_grp2 = '0;
    logic [13:0] ev_grp3 = '0;
    logic [0:0]  ev_grp4 = '0;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    evbank_top #(.NCNT(4), .ADDR_W(14)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_grp1(ev_grp1),
        .ev_grp2(ev_grp2), .ev_grp3(ev_grp3), .ev_grp4(ev_grp4)
    );

    function automatic logic [13:0] sel_a(int i); return 14'(16'h2000 + 8 * i); endfunction
    function automatic logic [13:0] cnt_a(int i); return 14'(16'h3000 + 8 * i); endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr32(logic [13:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic wr64(logic [13:0] a, logic [63:0] d);
        wr32(a, d[31:0]); wr32(a + 14'd4, d[63:32]);
    endtask

    task automatic rd32(logic [13:0] a, output logic [31:0] v);
        @(negedge clk); bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic rd64(logic [13:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd32(a, lo); rd32(a + 14'd4, hi); v = {hi, lo};
    endtask

    task automatic pulse(logic [19:0] g1, logic [18:0] g2, logic [13:0] g3, logic g4);
        @(negedge clk); ev_grp1 = g1; ev_grp2 = g2; ev_grp3 = g3; ev_grp4 = g4;
        @(negedge clk); ev_grp1 = '0; ev_grp2 = '0; ev_grp3 = '0; ev_grp4 = '0;
    endtask

    task automatic wr_pulse(logic [13:0] a, logic [31:0] d, logic [19:0] g1);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ev_grp1 = g1;
        @(negedge clk); bus_wr = 1'b0; ev_grp1 = '0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        wr64(sel_a(0), 64'h1234_0001); wr64(cnt_a(0), 64'h55); wr64(14'h2800, 64'h77);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
        rd64(sel_a(0), v); chk("R1 select cleared", v, 64'h0);
        rd64(cnt_a(0), v); chk("R1 count cleared", v, 64'h0);
        rd64(14'h2800, v); chk("R1 filter cleared", v, 64'h0);
    endtask

    task automatic t_map();
        logic [63:0] v;
        logic [31:0] w;
        wr32(sel_a(2) + 14'd4, 32'hCAFE_0000);
        rd64(sel_a(2), v); chk("R2 high word at +4", v, 64'hCAFE_0000_0000_0000);
        wr32(cnt_a(1), 32'h0000_0ABC);
        rd32(cnt_a(1), w); chk("R2 count low word", {32'h0, w}, 64'hABC);
        wr64(sel_a(2), 64'h0);
    endtask

    task automatic t_popcount();
        logic [63:0] v;
        wr64(cnt_a(0), 64'h0);
        wr64(sel_a(0), 64'h2901);   // group 1, events 0,3,5
        pulse(20'h000A9, '1, '1, 1'b1);   // events 0,3,5,7 fire
        rd64(cnt_a(0), v); chk("R4 three masked events in one cycle", v, 64'd3);
        pulse(20'h00008, '0, '0, 1'b0);
        rd64(cnt_a(0), v); chk("R4 single event adds one", v, 64'd4);
        wr64(cnt_a(1), 64'h0);
        wr64(sel_a(1), {37'h0, 19'h7FFFF, 8'd2});   // group 2, all 19 events
        pulse('1, '1, '0, 1'b0);
        rd64(cnt_a(1), v); chk("R3 group 2 all 19 events", v, 64'd19);
        pulse('1, '0, '1, 1'b1);
        rd64(cnt_a(1), v); chk("R3 other groups ignored", v, 64'd19);
        wr64(sel_a(0), 64'h0); wr64(sel_a(1), 64'h0);
    endtask

    task automatic t_invalid();
        logic [63:0] v;
        wr64(cnt_a(0), 64'h0);
        wr64(sel_a(0), 64'hFFFF_FFFF_FFFF_FF05);
        pulse('1, '1, '1, 1'b1);
        rd64(cnt_a(0), v); chk("R5 group 5 counts nothing", v, 64'h0);
        wr64(sel_a(0), 64'hFFFF_FFFF_FFFF_FF00);
        pulse('1, '1, '1, 1'b1);
        rd64(cnt_a(0), v); chk("R5 group 0 counts nothing", v, 64'h0);
        wr64(sel_a(0), 64'h0);
        pulse('1, '1, '1, 1'b1);
        rd64(cnt_a(0), v); chk("R5 zero select stops", v, 64'h0);
    endtask

    task automatic t_wide_mask();
        logic [63:0] v;
        wr64(cnt_a(3), 64'h0);
        wr64(sel_a(3), 64'hFFFF_FFFF_FFFF_FF04);
        pulse('1, '1, '1, 1'b1);
        rd64(cnt_a(3), v); chk("R6 group 4 full mask adds one", v, 64'd1);
        wr64(sel_a(3), 64'hFFFF_FFFF_FFFF_FF03);
        pulse('1, '1, '1, 1'b1);
        rd64(cnt_a(3), v); chk("R6 group 3 full mask adds fourteen", v, 64'd15);
    endtask

    task automatic t_priority();
        logic [63:0] v;
        wr64(sel_a(0), 64'h101);   // group 1 event 0
        wr64(cnt_a(0), 64'h0);
        wr_pulse(cnt_a(0), 32'd100, 20'h1);
        rd64(cnt_a(0), v); chk("R7 write wins over increment", v, 64'd100);
        pulse(20'h1, '0, '0, 1'b0);
        rd64(cnt_a(0), v); chk("R7 counting resumes", v, 64'd101);
        wr_pulse(cnt_a(0) + 14'd4, 32'd5, 20'h1);
        rd64(cnt_a(0), v); chk("R7 high write keeps low word", v, {32'd5, 32'd101});
        wr64(sel_a(0), 64'h0);
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        wr64(sel_a(3), 64'h0);
        wr64(cnt_a(3), 64'hFFFF_FFFF_FFFF_FFFE);
        wr64(sel_a(3), 64'h703);   // group 3, events 0..2
        pulse('0, '0, 14'h7, 1'b0);
        rd64(cnt_a(3), v); chk("R8 wrap modulo 2^64", v, 64'd1);
        wr64(sel_a(3), 64'h0);
    endtask

    task automatic t_unmapped();
        logic [63:0] v;
        logic [31:0] w;
        wr64(cnt_a(4), 64'hDEAD_BEEF_DEAD_BEEF);
        rd64(cnt_a(4), v); chk("R9 counter index NCNT unmapped", v, 64'h0);
        wr64(sel_a(4), 64'h0000_0000_0000_0101);
        rd64(sel_a(4), v); chk("R9 select index NCNT unmapped", v, 64'h0);
        rd32(14'h1000, w); chk("R9 far offset reads zero", {32'h0, w}, 64'h0);
        rd64(cnt_a(0), v); chk("R9 stray writes left counter 0", v, {32'd5, 32'd101});
    endtask

    task automatic t_filter();
        logic [63:0] v;
        wr64(14'h2800, 64'h0000_5A5A_A5A5_A5A5);
        rd64(14'h2800, v); chk("R10 filter stores both words", v, 64'h0000_5A5A_A5A5_A5A5);
        wr64(14'h2800, 64'h0);
        rd64(14'h2800, v); chk("R10 filter cleared", v, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_popcount();
        t_invalid();
        t_wide_mask();
        t_priority();
        t_wrap();
        t_unmapped();
        t_filter();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule